// File: doc/BRIEF.md
# Receive Header Checker for Protocol-Mode Link Channels

This block sits in the receive path of one link channel, between the token decoder and the receive FIFO. In protocol mode it treats the first four data bytes of every packet as a header. A packet starts after reset or after an end-of-packet token. The header bytes are, in order: destination address, command code, transaction ID and control byte. The block compares the destination against the channel's own address and sorts the command code into one of four kinds: a data write, a control command, the safety-arm command, or an invalid code. Only data-write packets reach the receive FIFO. Control commands become a one-cycle request to the command executor. Each accepted header is also offered to the acknowledge generator.

Two of the control commands are safety-critical. They execute only while an arm latch is set. The arm command sets the latch, and the first safety-critical command that executes clears it again. An address mismatch, an invalid code, a disarmed safety-critical command, or a packet that ends inside its header each raise an error pulse with a code. In transparent and routing modes the block is a wire: tokens and back-pressure pass straight through. The mode input is driven from channel configuration, which resets to transparent.

Tokens enter and leave on valid/ready streams. A token moves when valid and ready are both high on a rising clock edge. While a payload is being forwarded, `in_ready` follows `out_ready`, so a stalled FIFO stalls the link side with no storage in between. Header bytes and discarded payload are always accepted. The command, acknowledge and error outputs are plain one-cycle pulses with no handshake.

Top module: `pkt_hdr_checker`

## Requirements
- R1: With `mode` 00 (transparent) or 01 (routing), `out_valid`, `out_data` and `out_eop` follow the input stream combinationally and `in_ready` equals `out_ready`; no command, acknowledge or error pulse is produced.
- R2: With `mode` 10 (protocol), the first four data tokens after reset or after an end-of-packet token (`in_eop`=1) are consumed as header bytes in the order address, command, transaction ID, control, and none of them is forwarded.
- R3: A header whose address equals `chan_addr` and whose command is 0x01 forwards every following payload byte and the closing end-of-packet token on the output stream, holds `in_ready` low while `out_ready` is low, and pulses `ack_valid` with `ack_addr`/`ack_cmd`.
- R4: Command codes 0x12 and 0x13, and codes 0x10 and 0x11 while armed, pulse `cmd_valid` with `cmd_code` equal to the code and pulse `ack_valid`; the rest of that packet is consumed and not forwarded.
- R5: An address mismatch pulses `err_valid` with `err_code` 2 and discards the packet; the address check takes precedence over any command check.
- R6: A matching address with any command code other than 0x01, 0x10–0x13 or 0x1F pulses `err_valid` with `err_code` 3 and discards the packet.
- R7: Codes 0x10 or 0x11 while `safe_armed` is 0 pulse `err_valid` with `err_code` 4, produce no `cmd_valid`, and discard the packet.
- R8: Code 0x1F sets `safe_armed` without a command request. Execution of code 0x10 or 0x11 clears it. Codes 0x12 and 0x13 leave it unchanged.
- R9: An end-of-packet token after one to three header bytes pulses `err_valid` with `err_code` 1, forwards nothing and restarts header capture. An end-of-packet token with no header byte pending is silently consumed.
- R10: On every completed header, including rejected ones, `hdr_tid` and `hdr_ctrl` take the third and fourth header bytes and hold them until the next completed header.
- R11: The command, acknowledge and error pulses are high for exactly the one cycle that follows the clock edge on which the fourth header byte (or the short-header end token) is accepted.
- R12: After reset all pulses are low, `safe_armed`, `hdr_tid` and `hdr_ctrl` are 0, and the first data byte in protocol mode is taken as an address byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | 00 transparent, 01 routing, 10 protocol, 11 treated as transparent |
| chan_addr | input | 8 | This channel's address |
| in_valid | input | 1 | Input token valid |
| in_ready | output | 1 | Input token accepted |
| in_data | input | 8 | Input data byte |
| in_eop | input | 1 | Input token is an end-of-packet marker |
| out_valid | output | 1 | Token valid toward the receive FIFO |
| out_ready | input | 1 | Receive FIFO can take a token |
| out_data | output | 8 | Forwarded data byte |
| out_eop | output | 1 | Forwarded token is an end-of-packet marker |
| cmd_valid | output | 1 | One-cycle command execution request |
| cmd_code | output | 8 | Command code of the request |
| ack_valid | output | 1 | One-cycle header offer to the acknowledge generator |
| ack_addr | output | 8 | Address byte of the accepted header |
| ack_cmd | output | 8 | Command byte of the accepted header |
| hdr_tid | output | 8 | Latched transaction ID of the last complete header |
| hdr_ctrl | output | 8 | Latched control byte of the last complete header |
| err_valid | output | 1 | One-cycle error pulse |
| err_code | output | 3 | 1 short header, 2 address, 3 invalid command, 4 disarmed safety command |
| safe_armed | output | 1 | Safety-critical command arm latch |

## Verification
The hardest behaviour to reach is the arm latch across packets. Whether a 0x10 or 0x11 command executes or errors depends on the whole history of arm commands, non-critical commands and rejected headers before it. The stimulus table is therefore ordered, not independent: one arm command is followed by a non-critical control command, then a critical command that executes, then a second critical command that must fail. A short header and a payload stalled by back-pressure are set up by driving the token stream one token at a time, with end-of-packet placed mid-header and `out_ready` held low while a payload byte waits.

// File: rtl/hdrchk_pkg.sv
package hdrchk_pkg;
  localparam int HDR_LEN = 4;
  localparam int IDX_ADDR = 0;
  localparam int IDX_CMD = 1;
  localparam int IDX_TID = 2;

  localparam logic [1:0] MODE_TRANSPARENT = 2'b00;
  localparam logic [1:0] MODE_ROUTE = 2'b01;
  localparam logic [1:0] MODE_PROTOCOL = 2'b10;

  localparam logic [2:0] ERR_NONE = 3'd0;
  localparam logic [2:0] ERR_SHORT = 3'd1;
  localparam logic [2:0] ERR_ADDR = 3'd2;
  localparam logic [2:0] ERR_CMD = 3'd3;
  localparam logic [2:0] ERR_LOCKED = 3'd4;

  typedef enum logic [1:0] {ST_HDR, ST_PASS, ST_DROP} rx_state_e;

  typedef enum logic [2:0] {
    V_DATA, V_CTRL, V_ARM, V_BAD_ADDR, V_BAD_CMD, V_LOCKED
  } verdict_e;
endpackage

// File: rtl/hdrchk_capture.sv
module hdrchk_capture
  import hdrchk_pkg::*;
#(
  parameter int W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic take,
  input  logic abort,
  input  logic [W-1:0] din,
  output logic done,
  output logic partial,
  output logic [HDR_LEN-2:0][W-1:0] bytes_q
);
  localparam int CNT_W = $clog2(HDR_LEN);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HDR_LEN - 1);

  logic [CNT_W-1:0] cnt;

  assign done = take && (cnt == LAST);
  assign partial = (cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n || clear || abort || done) cnt <= '0;
    else if (take) cnt <= cnt + CNT_W'(1);
  end

  for (genvar i = 0; i < HDR_LEN - 1; i++) begin : g_byte
    always_ff @(posedge clk) begin
      if (!rst_n) bytes_q[i] <= '0;
      else if (take && cnt == CNT_W'(i)) bytes_q[i] <= din;
    end
  end

  AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !partial); // R2
  AST_ABORT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !partial); // R9
endmodule

// File: rtl/hdrchk_decode.sv
module hdrchk_decode
  import hdrchk_pkg::*;
#(
  parameter int W = 8,
  parameter logic [W-1:0] CMD_DATA = 8'h01,
  parameter logic [W-1:0] CTRL_LO = 8'h10,
  parameter logic [W-1:0] CTRL_HI = 8'h13,
  parameter logic [W-1:0] SAFE_LO = 8'h10,
  parameter logic [W-1:0] SAFE_HI = 8'h11,
  parameter logic [W-1:0] CMD_ARM = 8'h1F
) (
  input  logic [W-1:0] addr,
  input  logic [W-1:0] cmd,
  input  logic [W-1:0] chan_addr,
  input  logic armed,
  output verdict_e verdict,
  output logic is_safety
);
  logic is_ctrl;

  always_comb begin
    is_ctrl = (cmd >= CTRL_LO) && (cmd <= CTRL_HI);
    is_safety = (cmd >= SAFE_LO) && (cmd <= SAFE_HI);
    if (addr != chan_addr) verdict = V_BAD_ADDR;
    else if (cmd == CMD_DATA) verdict = V_DATA;
    else if (cmd == CMD_ARM) verdict = V_ARM;
    else if (is_ctrl && is_safety && !armed) verdict = V_LOCKED;
    else if (is_ctrl) verdict = V_CTRL;
    else verdict = V_BAD_CMD;
  end
endmodule

// File: rtl/hdrchk_safety.sv
module hdrchk_safety (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic fire_safe,
  output logic armed
);
  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else if (arm) armed <= 1'b1;
    else if (fire_safe) armed <= 1'b0;
  end

  AST_ARM_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> armed); // R8
  AST_DISARM_ONLY_ON_USE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(armed) |-> $past(fire_safe)); // R8
  AST_FIRE_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    fire_safe |-> armed); // R7
endmodule

// File: rtl/pkt_hdr_checker.sv
module pkt_hdr_checker
  import hdrchk_pkg::*;
#(
  parameter int W = 8,
  parameter int ERR_W = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic [1:0] mode,
  input  logic [W-1:0] chan_addr,
  input  logic in_valid,
  output logic in_ready,
  input  logic [W-1:0] in_data,
  input  logic in_eop,
  output logic out_valid,
  input  logic out_ready,
  output logic [W-1:0] out_data,
  output logic out_eop,
  output logic cmd_valid,
  output logic [W-1:0] cmd_code,
  output logic ack_valid,
  output logic [W-1:0] ack_addr,
  output logic [W-1:0] ack_cmd,
  output logic [W-1:0] hdr_tid,
  output logic [W-1:0] hdr_ctrl,
  output logic err_valid,
  output logic [ERR_W-1:0] err_code,
  output logic safe_armed
);
  rx_state_e state;
  logic proto, fire, in_hdr, hdr_take, hdr_abort;
  logic done, partial, is_safety, arm_req, fire_safe;
  logic [HDR_LEN-2:0][W-1:0] hbytes;
  verdict_e verdict;

  assign proto = (mode == MODE_PROTOCOL);
  assign in_hdr = proto && (state == ST_HDR);

  always_comb begin
    if (!proto) begin
      in_ready = out_ready;
      out_valid = in_valid;
    end else if (state == ST_PASS) begin
      in_ready = out_ready;
      out_valid = in_valid;
    end else begin
      in_ready = 1'b1;
      out_valid = 1'b0;
    end
  end
  assign out_data = in_data;
  assign out_eop = in_eop;

  assign fire = in_valid && in_ready;
  assign hdr_take = in_hdr && fire && !in_eop;
  assign hdr_abort = in_hdr && fire && in_eop;

  hdrchk_capture #(.W(W)) u_cap (
    .clk(clk), .rst_n(rst_n), .clear(!proto), .take(hdr_take),
    .abort(hdr_abort), .din(in_data), .done(done), .partial(partial),
    .bytes_q(hbytes)
  );

  hdrchk_decode #(.W(W)) u_dec (
    .addr(hbytes[IDX_ADDR]), .cmd(hbytes[IDX_CMD]), .chan_addr(chan_addr),
    .armed(safe_armed), .verdict(verdict), .is_safety(is_safety)
  );

  assign arm_req = done && (verdict == V_ARM);
  assign fire_safe = done && (verdict == V_CTRL) && is_safety;

  hdrchk_safety u_safe (
    .clk(clk), .rst_n(rst_n), .arm(arm_req), .fire_safe(fire_safe),
    .armed(safe_armed)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_HDR;
      cmd_valid <= 1'b0;
      cmd_code <= '0;
      ack_valid <= 1'b0;
      ack_addr <= '0;
      ack_cmd <= '0;
      hdr_tid <= '0;
      hdr_ctrl <= '0;
      err_valid <= 1'b0;
      err_code <= ERR_NONE;
    end else begin
      cmd_valid <= 1'b0;
      ack_valid <= 1'b0;
      err_valid <= 1'b0;
      if (!proto) begin
        state <= ST_HDR;
      end else begin
        unique case (state)
          ST_HDR: begin
            if (hdr_abort && partial) begin
              err_valid <= 1'b1;
              err_code <= ERR_SHORT;
            end
            if (done) begin
              hdr_tid <= hbytes[IDX_TID];
              hdr_ctrl <= in_data;
              state <= ST_DROP;
              unique case (verdict)
                V_DATA, V_ARM: begin
                  ack_valid <= 1'b1;
                  ack_addr <= hbytes[IDX_ADDR];
                  ack_cmd <= hbytes[IDX_CMD];
                  if (verdict == V_DATA) state <= ST_PASS;
                end
                V_CTRL: begin
                  ack_valid <= 1'b1;
                  ack_addr <= hbytes[IDX_ADDR];
                  ack_cmd <= hbytes[IDX_CMD];
                  cmd_valid <= 1'b1;
                  cmd_code <= hbytes[IDX_CMD];
                end
                V_BAD_ADDR: begin
                  err_valid <= 1'b1;
                  err_code <= ERR_ADDR;
                end
                V_BAD_CMD: begin
                  err_valid <= 1'b1;
                  err_code <= ERR_CMD;
                end
                default: begin
                  err_valid <= 1'b1;
                  err_code <= ERR_LOCKED;
                end
              endcase
            end
          end
          ST_PASS, ST_DROP: if (fire && in_eop) state <= ST_HDR;
          default: state <= ST_HDR;
        endcase
      end
    end
  end

  AST_BYPASS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!proto && $past(!proto)) |-> !(err_valid || cmd_valid || ack_valid)); // R1
  AST_STALL_HOLDS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (proto && out_valid && !out_ready) |-> !in_ready); // R3
  AST_CMD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid); // R11
  AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |=> !err_valid); // R11
  AST_CMD_NOT_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && err_valid)); // R7
  AST_SHORT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (err_valid && err_code == ERR_SHORT) |-> $past(in_valid && in_eop)); // R9
endmodule

// File: tb/sim_pkt_hdr_checker.sv
module sim_pkt_hdr_checker;
  typedef struct packed {
    logic [7:0] addr, cmd, tid, ctrl, plen;
    logic [2:0] err;
    logic cmd_exp, ack_exp;
    logic [7:0] fwd;
    logic armed;
  } vec_t;

  localparam int NV = 11;
  localparam logic [7:0] MY_ADDR = 8'h5A;
  localparam vec_t VECS [NV] = '{
    '{8'h5A, 8'h01, 8'h11, 8'h21, 8'd3, 3'd0, 1'b0, 1'b1, 8'd4, 1'b0},
    '{8'h5A, 8'h12, 8'h12, 8'h22, 8'd2, 3'd0, 1'b1, 1'b1, 8'd0, 1'b0},
    '{8'h33, 8'h01, 8'h13, 8'h23, 8'd2, 3'd2, 1'b0, 1'b0, 8'd0, 1'b0},
    '{8'h33, 8'h77, 8'h14, 8'h24, 8'd1, 3'd2, 1'b0, 1'b0, 8'd0, 1'b0},
    '{8'h5A, 8'h77, 8'h15, 8'h25, 8'd1, 3'd3, 1'b0, 1'b0, 8'd0, 1'b0},
    '{8'h5A, 8'h10, 8'h16, 8'h26, 8'd0, 3'd4, 1'b0, 1'b0, 8'd0, 1'b0},
    '{8'h5A, 8'h1F, 8'h17, 8'h27, 8'd0, 3'd0, 1'b0, 1'b1, 8'd0, 1'b1},
    '{8'h5A, 8'h13, 8'h18, 8'h28, 8'd1, 3'd0, 1'b1, 1'b1, 8'd0, 1'b1},
    '{8'h5A, 8'h11, 8'h19, 8'h29, 8'd0, 3'd0, 1'b1, 1'b1, 8'd0, 1'b0},
    '{8'h5A, 8'h11, 8'h1A, 8'h2A, 8'd0, 3'd4, 1'b0, 1'b0, 8'd0, 1'b0},
    '{8'h5A, 8'h01, 8'h1B, 8'h2B, 8'd0, 3'd0, 1'b0, 1'b1, 8'd1, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic in_valid = 1'b0, in_eop = 1'b0, out_ready = 1'b1;
  logic [7:0] in_data = '0;
  logic in_ready, out_valid, out_eop, cmd_valid, ack_valid, err_valid, safe_armed;
  logic [7:0] out_data, cmd_code, ack_addr, ack_cmd, hdr_tid, hdr_ctrl;
  logic [2:0] err_code;

  int checks = 0, failures = 0;
  int n_fwd = 0, n_err = 0, n_cmd = 0, n_ack = 0;
  logic [2:0] last_err = '0;
  logic [7:0] last_cmd = '0;

  always #2 clk = ~clk;

  pkt_hdr_checker u0 (
    .clk(clk), .rst_n(rst_n), .mode(mode), .chan_addr(MY_ADDR),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_eop(in_eop),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_eop(out_eop),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .ack_valid(ack_valid),
    .ack_addr(ack_addr), .ack_cmd(ack_cmd), .hdr_tid(hdr_tid), .hdr_ctrl(hdr_ctrl),
    .err_valid(err_valid), .err_code(err_code), .safe_armed(safe_armed)
  );

  always @(posedge clk) begin
    if (rst_n) begin
      if (out_valid && out_ready) n_fwd <= n_fwd + 1;
      if (err_valid) begin n_err <= n_err + 1; last_err <= err_code; end
      if (cmd_valid) begin n_cmd <= n_cmd + 1; last_cmd <= cmd_code; end
      if (ack_valid) n_ack <= n_ack + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send_tok(input logic [7:0] d, input logic eop);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_eop = eop;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(posedge clk);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_valid = 1'b0; in_eop = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_pkt(input vec_t v);
    send_tok(v.addr, 1'b0);
    send_tok(v.cmd, 1'b0);
    send_tok(v.tid, 1'b0);
    send_tok(v.ctrl, 1'b0);
    for (int i = 0; i < int'(v.plen); i++) send_tok(8'h40 + 8'(i), 1'b0);
    send_tok(8'h00, 1'b1);
    idle(2);
  endtask

  function automatic string tag_of(input vec_t v);
    case (v.err)
      3'd1: return "R9";
      3'd2: return "R5";
      3'd3: return "R6";
      3'd4: return "R7";
      default: begin
        if (v.cmd == 8'h1F) return "R8";
        if (v.cmd_exp) return "R4";
        return "R3";
      end
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int b_fwd, b_err, b_cmd, b_ack;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    check(!cmd_valid && !ack_valid && !err_valid, "R12 pulses", {cmd_valid, ack_valid, err_valid}, 0);
    check(safe_armed == 1'b0, "R12 armed", safe_armed, 0);
    check(hdr_tid == 8'h00 && hdr_ctrl == 8'h00, "R12 latches", {hdr_tid, hdr_ctrl}, 0);

    // R1 transparent and routing bypass
    for (int m = 0; m < 2; m++) begin
      mode = 2'(m);
      @(negedge clk);
      in_valid = 1'b1; in_data = 8'hA5; in_eop = 1'b1; out_ready = 1'b0;
      #1;
      check(out_valid && out_data == 8'hA5 && out_eop, "R1 mirror", {out_valid, out_data}, 9'h1A5);
      check(in_ready == 1'b0, "R1 ready follows", in_ready, 0);
      out_ready = 1'b1;
      #1;
      check(in_ready == 1'b1, "R1 ready follows", in_ready, 1);
      idle(1);
      b_fwd = n_fwd; b_err = n_err;
      send_pkt(VECS[3]);
      check(n_fwd - b_fwd == 6, "R1 all forwarded", n_fwd - b_fwd, 6);
      check(n_err == b_err && !safe_armed, "R1 no checking", n_err - b_err, 0);
    end

    // ordered vector table, protocol mode (R12: first byte parsed as address)
    mode = 2'b10;
    idle(1);
    for (int k = 0; k < NV; k++) begin
      b_fwd = n_fwd; b_err = n_err; b_cmd = n_cmd; b_ack = n_ack;
      send_pkt(VECS[k]);
      check(n_err - b_err == (VECS[k].err != 0 ? 1 : 0) &&
            (VECS[k].err == 0 || last_err == VECS[k].err),
            tag_of(VECS[k]), last_err, VECS[k].err);
      check(n_cmd - b_cmd == int'(VECS[k].cmd_exp) &&
            (!VECS[k].cmd_exp || last_cmd == VECS[k].cmd),
            tag_of(VECS[k]), n_cmd - b_cmd, VECS[k].cmd_exp);
      check(n_fwd - b_fwd == int'(VECS[k].fwd), tag_of(VECS[k]), n_fwd - b_fwd, VECS[k].fwd);
      check(n_ack - b_ack == int'(VECS[k].ack_exp), tag_of(VECS[k]), n_ack - b_ack, VECS[k].ack_exp);
      check(hdr_tid == VECS[k].tid && hdr_ctrl == VECS[k].ctrl, "R10 latches",
            {hdr_tid, hdr_ctrl}, {VECS[k].tid, VECS[k].ctrl});
      check(safe_armed == VECS[k].armed, "R8 arm latch", safe_armed, VECS[k].armed);
    end

    // R3 back-pressure on payload, R2 header not forwarded
    b_fwd = n_fwd;
    send_tok(MY_ADDR, 1'b0); send_tok(8'h01, 1'b0);
    send_tok(8'h31, 1'b0); send_tok(8'h32, 1'b0);
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b1; in_data = 8'h40; in_eop = 1'b0;
    repeat (3) @(negedge clk);
    check(in_ready == 1'b0, "R3 stall", in_ready, 0);
    check(out_valid && out_data == 8'h40, "R2 first forwarded is payload", out_data, 8'h40);
    check(n_fwd == b_fwd, "R3 nothing moved", n_fwd - b_fwd, 0);
    out_ready = 1'b1;
    @(posedge clk);
    send_tok(8'h00, 1'b1);
    idle(2);
    check(n_fwd - b_fwd == 2, "R3 after release", n_fwd - b_fwd, 2);

    // R9 short header, lone EOP, recovery
    b_fwd = n_fwd; b_err = n_err;
    send_tok(MY_ADDR, 1'b0); send_tok(8'h01, 1'b0); send_tok(8'h00, 1'b1);
    idle(2);
    check(n_err - b_err == 1 && last_err == 3'd1, "R9 short", last_err, 1);
    check(n_fwd == b_fwd, "R9 no forward", n_fwd - b_fwd, 0);
    b_err = n_err;
    send_tok(8'h00, 1'b1);
    idle(2);
    check(n_err == b_err, "R9 lone eop", n_err - b_err, 0);
    send_pkt(VECS[0]);
    check(n_fwd - b_fwd == 4, "R9 restart", n_fwd - b_fwd, 4);

    // R11 pulse timing
    send_tok(MY_ADDR, 1'b0); send_tok(8'h77, 1'b0);
    send_tok(8'h01, 1'b0); send_tok(8'h02, 1'b0);
    @(negedge clk);
    in_valid = 1'b0;
    check(err_valid && err_code == 3'd3, "R11 pulse cycle", {err_valid, err_code}, 4'hB);
    @(negedge clk);
    check(!err_valid, "R11 one cycle", err_valid, 0);
    send_tok(8'h00, 1'b1);
    idle(2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule